// File: doc/BRIEF.md
# Key-protected debug halt controller

This block sits between an external debugger and a simple processor core. It lets the debugger halt the core, resume it, and single-step it. The debugger talks to the block through a word-addressed register port. The block drives three lines into the core: halt, step-enable and interrupt-mask. It reads back live status from the core and keeps sticky records of retired instructions and core resets.

The control word is guarded by an unlock value. A write changes the control bits only when its upper half holds that value. A read of the same word returns core status in the upper half. Each step runs one instruction, and the core is then parked again. A second register holds event-catch enables. With these set, a core reset or a hard fault re-halts the core without the debugger taking part.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: After reset the control word, the catch register and both sticky flags are zero. The core_halt, core_step_en, core_mask_irq and trace_en outputs are low.
- R2: A write to word 0 (control) changes the control bits only when wdata[31:16] equals 16'hA05F. Any other upper value leaves the control bits as they were. Control bits: [0] enable, [1] halt, [2] step, [3] irq mask, [5] snap stall.
- R3: A keyed write that sets enable and halt raises core_halt on the next clock edge. Read bit 17 follows the core_halted input.
- R4: core_halt, core_step_en and core_mask_irq are the halt, step and irq-mask bits ANDed with enable. A keyed write with all control bits clear therefore drops all three outputs.
- R5: A keyed write updates the step and irq-mask bits only if core_halted is high in the write cycle. Otherwise those two bits keep their values.
- R6: While enable and step are set and halt is clear, a core_retire pulse sets the halt bit. core_halt is then high after that edge.
- R7: Reading word 0 returns the control bits in [5:0] and live status in bits 16 (core_regrdy), 17 (core_halted), 18 (core_sleeping) and 19 (core_lockup). Bits 4, 15:6, 23:20 and 31:26 read 0.
- R8: Read bit 24 is set by core_retire and bit 25 by core_in_reset. Both stay set until word 0 is read. An event in the same cycle as that read leaves its bit set.
- R9: Word 1 (catch) is written without any key and keeps only bits 0, 10:4 and 24. All other bits read 0. trace_en equals bit 24.
- R10: With enable and catch bit 0 set, core_in_reset sets the halt bit. core_halt is high after the first edge of reset and stays high after reset ends.
- R11: With enable and catch bit 10 set, a core_hardfault pulse sets the halt bit. Catch bits 9:4 are stored only and cause no halt.
- R12: With enable clear, neither catch event nor a retire pulse sets the halt bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word index: 0 control/status, 1 catch |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| core_halted | input | 1 | Core is parked in debug state |
| core_sleeping | input | 1 | Core is sleeping |
| core_lockup | input | 1 | Core is locked up |
| core_retire | input | 1 | One-cycle pulse per retired instruction |
| core_in_reset | input | 1 | Core is held in reset |
| core_hardfault | input | 1 | One-cycle pulse on a hard fault |
| core_regrdy | input | 1 | Core register transfer complete |
| core_halt | output | 1 | Halt request to the core |
| core_step_en | output | 1 | Single-step enable to the core |
| core_mask_irq | output | 1 | Interrupt mask to the core |
| trace_en | output | 1 | Trace enable from the catch register |

## Verification
Assertions check the following on every cycle:
- an unkeyed write freezes the control bits;
- step and mask hold while the core runs;
- outputs stay low without enable;
- a step retire or a reset catch re-halts the core;
- a set event always lands in its sticky flag, and a read clears a flag that saw no event;
- no unimplemented catch bit is ever set.

Only the bench scenarios can show the rest:
- the exact read word for each layout;
- the same-cycle race between a read and a retire;
- that catch bits 9:4 and a disabled block leave the core running;
- the sequence of a full halt, step and re-halt.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;

  localparam int unsigned WORD_W     = 32;
  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;
  localparam logic [31:0] CATCH_KEEP = 32'h0100_07F1;

  localparam int unsigned CB_EN    = 0;
  localparam int unsigned CB_HALT  = 1;
  localparam int unsigned CB_STEP  = 2;
  localparam int unsigned CB_MASK  = 3;
  localparam int unsigned CB_SNAP  = 5;

  localparam int unsigned SB_REGRDY = 16;
  localparam int unsigned SB_HALTED = 17;
  localparam int unsigned SB_SLEEP  = 18;
  localparam int unsigned SB_LOCK   = 19;
  localparam int unsigned SB_RETIRE = 24;
  localparam int unsigned SB_RESET  = 25;

  localparam int unsigned VC_RESET  = 0;
  localparam int unsigned VC_HFAULT = 10;
  localparam int unsigned VC_TRACE  = 24;

  typedef struct packed {
    logic snap;
    logic mask;
    logic step;
    logic halt;
    logic en;
  } ctrl_t;

  function automatic logic key_ok(input logic [WORD_W-1:0] w);
    return w[31:16] == UNLOCK_KEY;
  endfunction

  function automatic logic [WORD_W-1:0] pack_status(
      input ctrl_t c, input logic regrdy, input logic halted,
      input logic sleeping, input logic lockup,
      input logic retire_seen, input logic reset_seen);
    logic [WORD_W-1:0] w;
    w            = '0;
    w[CB_EN]     = c.en;
    w[CB_HALT]   = c.halt;
    w[CB_STEP]   = c.step;
    w[CB_MASK]   = c.mask;
    w[CB_SNAP]   = c.snap;
    w[SB_REGRDY] = regrdy;
    w[SB_HALTED] = halted;
    w[SB_SLEEP]  = sleeping;
    w[SB_LOCK]   = lockup;
    w[SB_RETIRE] = retire_seen;
    w[SB_RESET]  = reset_seen;
    return w;
  endfunction

endpackage

// File: rtl/dbg_ctrl_reg.sv
module dbg_ctrl_reg
  import dbg_halt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  input  logic              core_halted,
  input  logic              halt_set,
  output ctrl_t             ctrl_q
);

  logic unlocked;
  logic step_mask_open;

  assign unlocked       = wr_en && key_ok(wdata);
  assign step_mask_open = unlocked && core_halted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      if (unlocked) begin
        ctrl_q.en   <= wdata[CB_EN];
        ctrl_q.halt <= wdata[CB_HALT];
        ctrl_q.snap <= wdata[CB_SNAP];
      end
      if (step_mask_open) begin
        ctrl_q.step <= wdata[CB_STEP];
        ctrl_q.mask <= wdata[CB_MASK];
      end
      if (halt_set) ctrl_q.halt <= 1'b1;
    end
  end

  assert_locked_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !key_ok(wdata) && !halt_set) |=> $stable(ctrl_q));

  assert_step_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !core_halted |=> ($stable(ctrl_q.step) && $stable(ctrl_q.mask)));

endmodule

// File: rtl/dbg_sticky_flags.sv
module dbg_sticky_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] q_o
);

  for (genvar k = 0; k < N; k++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q_o[k] <= 1'b0;
      else if (set_i[k])   q_o[k] <= 1'b1;
      else if (clr_i)      q_o[k] <= 1'b0;
    end

    assert_sticky_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[k] |=> q_o[k]);

    assert_sticky_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i[k]) |=> !q_o[k]);
  end

endmodule

// File: rtl/dbg_catch_reg.sv
module dbg_catch_reg
  import dbg_halt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] catch_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     catch_q <= '0;
    else if (wr_en) catch_q <= wdata & CATCH_KEEP;
  end

  assert_catch_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (catch_q & ~CATCH_KEEP) == '0);

endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned CTRL_IDX  = 0,
  parameter int unsigned CATCH_IDX = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              core_halted,
  input  logic              core_sleeping,
  input  logic              core_lockup,
  input  logic              core_retire,
  input  logic              core_in_reset,
  input  logic              core_hardfault,
  input  logic              core_regrdy,
  output logic              core_halt,
  output logic              core_step_en,
  output logic              core_mask_irq,
  output logic              trace_en
);

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_IDX);
  localparam logic [ADDR_W-1:0] A_CATCH = ADDR_W'(CATCH_IDX);
  localparam int unsigned       NFLAG   = 2;

  ctrl_t             ctrl_q;
  logic [WORD_W-1:0] catch_q;
  logic [NFLAG-1:0]  flag_q;
  logic [NFLAG-1:0]  flag_set;

  logic sel_ctrl, sel_catch;
  logic wr_ctrl, wr_catch, rd_ctrl;
  logic ev_reset_catch, ev_fault_catch, ev_step_done, halt_set;

  assign sel_ctrl  = bus_valid && (bus_addr == A_CTRL);
  assign sel_catch = bus_valid && (bus_addr == A_CATCH);
  assign wr_ctrl   = sel_ctrl  && bus_write;
  assign wr_catch  = sel_catch && bus_write;
  assign rd_ctrl   = sel_ctrl  && !bus_write;

  assign ev_reset_catch = ctrl_q.en && catch_q[VC_RESET]  && core_in_reset;
  assign ev_fault_catch = ctrl_q.en && catch_q[VC_HFAULT] && core_hardfault;
  assign ev_step_done   = ctrl_q.en && ctrl_q.step && !ctrl_q.halt && core_retire;
  assign halt_set       = ev_reset_catch || ev_fault_catch || ev_step_done;

  assign flag_set = {core_in_reset, core_retire};

  dbg_ctrl_reg u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_ctrl),
    .wdata       (bus_wdata),
    .core_halted (core_halted),
    .halt_set    (halt_set),
    .ctrl_q      (ctrl_q)
  );

  dbg_sticky_flags #(.N(NFLAG)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (flag_set),
    .clr_i (rd_ctrl),
    .q_o   (flag_q)
  );

  dbg_catch_reg u_catch (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_catch),
    .wdata   (bus_wdata),
    .catch_q (catch_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl)
      bus_rdata = pack_status(ctrl_q, core_regrdy, core_halted, core_sleeping,
                              core_lockup, flag_q[0], flag_q[1]);
    else if (sel_catch)
      bus_rdata = catch_q;
  end

  assign core_halt     = ctrl_q.en && ctrl_q.halt;
  assign core_step_en  = ctrl_q.en && ctrl_q.step;
  assign core_mask_irq = ctrl_q.en && ctrl_q.mask;
  assign trace_en      = catch_q[VC_TRACE];

  assert_outputs_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.en |-> (!core_halt && !core_step_en && !core_mask_irq));

  assert_step_rehalt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_step_done |=> core_halt);

  assert_reset_catch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reset_catch |=> core_halt);

  assert_keyed_halt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && key_ok(bus_wdata) && bus_wdata[0] && bus_wdata[1]) |=> core_halt);

endmodule

// File: tb/dbg_halt_ctrl_tb.sv
module dbg_halt_ctrl_tb;

  localparam logic [31:0] KEY = 32'hA05F_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        core_halted = 0, core_sleeping = 0, core_lockup = 0;
  logic        core_retire = 0, core_in_reset = 0, core_hardfault = 0, core_regrdy = 0;
  logic        core_halt, core_step_en, core_mask_irq, trace_en;

  int checks = 0, errors = 0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  dbg_halt_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_halted(core_halted), .core_sleeping(core_sleeping), .core_lockup(core_lockup),
    .core_retire(core_retire), .core_in_reset(core_in_reset),
    .core_hardfault(core_hardfault), .core_regrdy(core_regrdy),
    .core_halt(core_halt), .core_step_en(core_step_en),
    .core_mask_irq(core_mask_irq), .trace_en(trace_en)
  );

  // vector: wdata[38:7], core_halted[6], expected control bits [5:0]
  localparam int NV = 8;
  localparam logic [38:0] VEC [NV] = '{
    {32'hA05F_0003, 1'b0, 6'h03},
    {32'h1234_0021, 1'b0, 6'h03},
    {32'hA05F_000F, 1'b0, 6'h03},
    {32'hA05F_000F, 1'b1, 6'h0F},
    {32'hA05F_0021, 1'b1, 6'h21},
    {32'hA05F_002D, 1'b0, 6'h21},
    {32'hA05F_0000, 1'b0, 6'h00},
    {32'h0000_000F, 1'b1, 6'h00}
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic chk_outs(input string req, input logic h, input logic s, input logic m);
    chk({core_halt, core_step_en, core_mask_irq} == {h, s, m}, req,
        {29'd0, core_halt, core_step_en, core_mask_irq}, {29'd0, h, s, m});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    do_read(2'd0, rd); chk(rd == 32'h0, "R1 ctrl", rd, 32'h0);
    do_read(2'd1, rd); chk(rd == 32'h0, "R1 catch", rd, 32'h0);
    chk_outs("R1 outputs", 0, 0, 0);
    chk(trace_en == 1'b0, "R1 trace_en", {31'd0, trace_en}, 32'h0);

    // R2 R3 R4 R5 table walk
    for (int i = 0; i < NV; i++) begin
      logic [31:0] exp;
      core_halted = VEC[i][6];
      do_write(2'd0, VEC[i][38:7]);
      exp = {26'd0, VEC[i][5:0]} | (32'(VEC[i][6]) << 17);
      do_read(2'd0, rd);
      chk(rd == exp, "R2/R5 table readback", rd, exp);
      chk_outs("R3/R4 table outputs", VEC[i][0] & VEC[i][1],
               VEC[i][0] & VEC[i][2], VEC[i][0] & VEC[i][3]);
    end
    core_halted = 0;

    // R7 live status layout
    core_regrdy = 1; core_halted = 1; core_sleeping = 1; core_lockup = 1;
    do_read(2'd0, rd); chk(rd == 32'h000F_0000, "R7 status layout", rd, 32'h000F_0000);
    core_regrdy = 0; core_sleeping = 0; core_lockup = 0;

    // R6 single step and re-halt
    do_write(2'd0, KEY | 32'h03);
    do_write(2'd0, KEY | 32'h0D);
    chk_outs("R6 stepping outputs", 0, 1, 1);
    core_halted = 0;
    @(negedge clk); core_retire = 1;
    @(negedge clk); core_retire = 0;
    chk_outs("R6 re-halt after retire", 1, 1, 1);

    // R8 sticky retire flag
    do_read(2'd0, rd); chk(rd == 32'h0100_000F, "R8 retire sticky set", rd, 32'h0100_000F);
    do_read(2'd0, rd); chk(rd == 32'h0000_000F, "R8 cleared by read", rd, 32'h0000_000F);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = 2'd0; core_retire = 1;
    #1 rd = bus_rdata;
    @(negedge clk); bus_valid = 0; core_retire = 0;
    chk(rd == 32'h0000_000F, "R8 read before race", rd, 32'h0000_000F);
    do_read(2'd0, rd); chk(rd == 32'h0100_000F, "R8 set wins over clear", rd, 32'h0100_000F);

    core_halted = 1;
    do_write(2'd0, KEY | 32'h01);
    core_halted = 0;
    do_read(2'd0, rd); chk(rd == 32'h0000_0001, "R5 cleanup readback", rd, 32'h1);

    // R9 catch register
    do_write(2'd1, 32'hFFFF_FFFF);
    do_read(2'd1, rd); chk(rd == 32'h0100_07F1, "R9 catch mask", rd, 32'h0100_07F1);
    chk(trace_en == 1'b1, "R9 trace_en", {31'd0, trace_en}, 32'h1);
    do_write(2'd1, 32'h0000_0001);
    chk(trace_en == 1'b0, "R9 trace_en off", {31'd0, trace_en}, 32'h0);

    // R10 reset catch
    @(negedge clk); core_in_reset = 1;
    @(negedge clk); chk_outs("R10 halt during reset", 1, 0, 0);
    core_in_reset = 0;
    @(negedge clk); chk_outs("R10 halt after reset", 1, 0, 0);
    do_read(2'd0, rd); chk(rd == 32'h0200_0003, "R10/R8 reset sticky", rd, 32'h0200_0003);

    // R12 catch ignored when disabled; R4 key alone disables
    do_write(2'd0, KEY);
    chk_outs("R4 key alone disables", 0, 0, 0);
    @(negedge clk); core_in_reset = 1;
    @(negedge clk); core_in_reset = 0;
    chk_outs("R12 no halt when disabled", 0, 0, 0);
    do_read(2'd0, rd); chk(rd == 32'h0200_0000, "R12 halt bit clear", rd, 32'h0200_0000);

    // R11 hard-fault catch
    do_write(2'd0, KEY | 32'h01);
    do_write(2'd1, 32'h0000_0400);
    @(negedge clk); core_hardfault = 1;
    @(negedge clk); core_hardfault = 0;
    chk_outs("R11 hard fault halts", 1, 0, 0);
    do_write(2'd0, KEY | 32'h01);
    do_write(2'd1, 32'h0000_03F0);
    @(negedge clk); core_hardfault = 1;
    @(negedge clk); core_hardfault = 0;
    chk_outs("R11 other catch bits inert", 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule